// File: doc/BRIEF.md
# Byte Shifter and Lane Pusher for 512-bit Vectors

This block moves data across a 512-bit vector in one of two ways. In shift mode it moves the vector right by a whole number of bytes. A single operand can be shifted with zero fill, or a second operand can supply the bytes that enter from the top, which makes the shift a funnel across two registers. In push mode a scalar of 8, 16 or 32 bits enters at one end of the vector. Every existing lane moves one lane toward the other end, and the lane at that far end is lost.

A request is one cycle with `valid_i` high. The result appears on `result_o` one clock later, together with `valid_o`. The result register keeps its value between requests, so a consumer can read it at any later cycle. Operation codes and lane-width codes are listed in the requirements below.

Top module: `vec_lane_shift`

## Requirements
- R1: While `rst_ni` is low, `valid_o` is 0 and `result_o` is all zeros.
- R2: `valid_o` equals `valid_i` delayed by one clock. A request accepted at clock edge N is visible on `result_o` after edge N.
- R3: When `valid_i` is low at an edge, `result_o` keeps its previous value whatever the other inputs carry.
- R4: When `op_i`=0 (single shift), `result_o` = `vec_a_i` shifted right by 8·`amt_i` bits and the vacated high bytes are zero. `amt_i` covers 0..63 bytes, and `vec_b_i` has no effect.
- R5: When `op_i`=1 (funnel shift), `result_o` is the low 512 bits of {`vec_b_i`,`vec_a_i`} shifted right by 8·`amt_i` bits. With `amt_i`=0 the result is `vec_a_i`.
- R6: When `op_i`=2 (push low), the scalar goes into lane 0 (the lowest bits). Each lane i of `vec_a_i` moves to lane i+1, and the old highest lane is dropped.
- R7: When `op_i`=3 (push high), the scalar goes into the highest lane. Each lane i of `vec_a_i` moves to lane i−1, and the old lane 0 is dropped.
- R8: In push modes `lw_i` picks the lane width: 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. Only the low lane-width bits of `scalar_i` are used.
- R9: In push modes `amt_i` and `vec_b_i` have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 2 | 0 single shift, 1 funnel shift, 2 push low, 3 push high |
| lw_i | input | 2 | Push lane width code |
| amt_i | input | 6 | Right shift amount in bytes |
| vec_a_i | input | 512 | Primary vector operand |
| vec_b_i | input | 512 | Upper operand for the funnel shift |
| scalar_i | input | 32 | Value pushed into the vector |
| valid_o | output | 1 | Result strobe, one cycle after `valid_i` |
| result_o | output | 512 | Registered result |

## Verification
Random requests with independent random operands are checked against a reference model. Because the two operands differ, the reference separates the single shift from the funnel shift, and separates an upward push from a downward one. Directed cases use shift amounts 0 and 63. Together they show whether zero fill and operand-B fill meet at the correct byte and whether the barrel stages are in the right order. Each push is tried at every lane width, with scalar upper bits set to garbage and with `amt_i` and `vec_b_i` changed. These cases show whether the wrong lane is dropped, whether stray scalar bits leak in, and whether the unused inputs have any effect. Idle cycles with changing inputs check that the result holds.

// File: rtl/vls_pkg.sv
package vls_pkg;
  typedef enum logic [1:0] {
    OP_SHR     = 2'd0,
    OP_FUNNEL  = 2'd1,
    OP_PUSH_LO = 2'd2,
    OP_PUSH_HI = 2'd3
  } vls_op_e;

  localparam int unsigned NUM_LW = 3;

  function automatic int unsigned lw_bits(int unsigned idx);
    return 8 << idx;
  endfunction
endpackage

// File: rtl/vls_funnel.sv
module vls_funnel #(
  parameter int unsigned VEC_W = 512,
  parameter int unsigned AMT_W = 6
) (
  input  logic             two_op_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic [VEC_W-1:0] lo_i,
  input  logic [VEC_W-1:0] hi_i,
  output logic [VEC_W-1:0] res_o
);
  localparam int unsigned DW = 2 * VEC_W;

  logic [DW-1:0] stage [AMT_W+1];
  logic          unused_upper;

  assign stage[0] = {two_op_i ? hi_i : {VEC_W{1'b0}}, lo_i};

  // log-depth barrel, stage k moves by 2^k bytes
  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    assign stage[k+1] = amt_i[k] ? (stage[k] >> (8 << k)) : stage[k];
  end

  assign res_o        = stage[AMT_W][VEC_W-1:0];
  assign unused_upper = ^stage[AMT_W][DW-1:VEC_W];
endmodule

// File: rtl/vls_push.sv
module vls_push #(
  parameter int unsigned VEC_W  = 512,
  parameter int unsigned SCAL_W = 32
) (
  input  logic              to_high_i,
  input  logic [1:0]        lw_i,
  input  logic [VEC_W-1:0]  vec_i,
  input  logic [SCAL_W-1:0] scalar_i,
  output logic [VEC_W-1:0]  res_o
);
  import vls_pkg::*;

  logic [VEC_W-1:0] up_w [NUM_LW];
  logic [VEC_W-1:0] dn_w [NUM_LW];
  logic [1:0]       sel;

  for (genvar i = 0; i < NUM_LW; i++) begin : g_lw
    localparam int unsigned W = lw_bits(i);
    assign up_w[i] = {vec_i[VEC_W-W-1:0], scalar_i[W-1:0]};
    assign dn_w[i] = {scalar_i[W-1:0], vec_i[VEC_W-1:W]};
  end

  // codes 2 and 3 both map to the widest lane
  assign sel   = (lw_i == 2'd3) ? 2'd2 : lw_i;
  assign res_o = to_high_i ? dn_w[sel] : up_w[sel];
endmodule

// File: rtl/vec_lane_shift.sv
module vec_lane_shift #(
  parameter int unsigned VEC_W  = 512,
  parameter int unsigned SCAL_W = 32
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            valid_i,
  input  logic [1:0]                      op_i,
  input  logic [1:0]                      lw_i,
  input  logic [$clog2(VEC_W/8)-1:0]      amt_i,
  input  logic [VEC_W-1:0]                vec_a_i,
  input  logic [VEC_W-1:0]                vec_b_i,
  input  logic [SCAL_W-1:0]               scalar_i,
  output logic                            valid_o,
  output logic [VEC_W-1:0]                result_o
);
  import vls_pkg::*;

  localparam int unsigned NBYTES = VEC_W / 8;
  localparam int unsigned AMT_W  = $clog2(NBYTES);

  vls_op_e          op;
  logic [VEC_W-1:0] shr_res, push_res, nxt_res;
  logic             is_push;

  assign op      = vls_op_e'(op_i);
  assign is_push = (op == OP_PUSH_LO) || (op == OP_PUSH_HI);

  vls_funnel #(.VEC_W(VEC_W), .AMT_W(AMT_W)) u_funnel (
    .two_op_i (op == OP_FUNNEL),
    .amt_i    (amt_i),
    .lo_i     (vec_a_i),
    .hi_i     (vec_b_i),
    .res_o    (shr_res)
  );

  vls_push #(.VEC_W(VEC_W), .SCAL_W(SCAL_W)) u_push (
    .to_high_i (op == OP_PUSH_HI),
    .lw_i      (lw_i),
    .vec_i     (vec_a_i),
    .scalar_i  (scalar_i),
    .res_o     (push_res)
  );

  assign nxt_res = is_push ? push_res : shr_res;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= nxt_res;
    end
  end

  assert_valid_delay_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));

  assert_hold_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));

  assert_shr_zero_amt_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'd0 && amt_i == '0) |=> result_o == $past(vec_a_i));

  assert_shr_zero_fill_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'd0 && amt_i != '0) |=> result_o[VEC_W-1 -: 8] == 8'h00);

  assert_funnel_top_byte_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'd1 && amt_i == AMT_W'(1))
      |=> result_o[VEC_W-1 -: 8] == $past(vec_b_i[7:0]));

  assert_push_lo_lane0_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'd2 && lw_i == 2'd0) |=> result_o[7:0] == $past(scalar_i[7:0]));

  assert_push_hi_top_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'd3 && lw_i[1])
      |=> result_o[VEC_W-1 -: 32] == $past(scalar_i[31:0]));

  assert_push_lo_16_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'd2 && lw_i == 2'd1)
      |=> result_o[31:0] == {$past(vec_a_i[15:0]), $past(scalar_i[15:0])});
endmodule

// File: tb/vec_lane_shift_bench.sv
module vec_lane_shift_bench;
  localparam int VW = 512;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          valid_i = 0;
  logic [1:0]    op_i = 0, lw_i = 0;
  logic [5:0]    amt_i = 0;
  logic [VW-1:0] a_i = '0, b_i = '0;
  logic [31:0]   s_i = 0;
  logic          valid_o;
  logic [VW-1:0] result_o;

  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vec_lane_shift u_vec_lane_shift (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .op_i(op_i), .lw_i(lw_i),
    .amt_i(amt_i), .vec_a_i(a_i), .vec_b_i(b_i), .scalar_i(s_i),
    .valid_o(valid_o), .result_o(result_o)
  );

  function automatic logic [VW-1:0] model(logic [1:0] op, logic [1:0] lw, logic [5:0] amt,
                                          logic [VW-1:0] a, logic [VW-1:0] b, logic [31:0] s);
    logic [2*VW-1:0] cat;
    logic [VW-1:0]   sc;
    int              w;
    w  = (lw == 0) ? 8 : (lw == 1) ? 16 : 32;
    sc = VW'(s) & ((VW'(1) << w) - 1);
    case (op)
      2'd0: return a >> (int'(amt) * 8);
      2'd1: begin cat = {b, a} >> (int'(amt) * 8); return cat[VW-1:0]; end
      2'd2: return (a << w) | sc;
      default: return (a >> w) | (sc << (VW - w));
    endcase
  endfunction

  function automatic logic [VW-1:0] rnd_vec();
    logic [VW-1:0] v;
    for (int i = 0; i < VW/32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(string tag, logic [VW-1:0] act, logic [VW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run(string tag, logic [1:0] op, logic [1:0] lw, logic [5:0] amt,
                     logic [VW-1:0] a, logic [VW-1:0] b, logic [31:0] s);
    logic [VW-1:0] exp;
    exp = model(op, lw, amt, a, b, s);
    @(negedge clk);
    valid_i = 1; op_i = op; lw_i = lw; amt_i = amt; a_i = a; b_i = b; s_i = s;
    @(negedge clk);
    valid_i = 0;
    check({tag, " R2 valid"}, VW'(valid_o), VW'(1));
    check(tag, result_o, exp);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] a, b, hold;
    void'($urandom(32'h5eed_1234));
    #23;
    check("R1 valid_o reset", VW'(valid_o), VW'(0));
    check("R1 result_o reset", result_o, '0);
    @(negedge clk); rst_n = 1;

    a = rnd_vec(); b = rnd_vec();
    run("R4 shr amt0", 2'd0, 2'd0, 6'd0, a, b, 32'h0);
    run("R4 shr amt63", 2'd0, 2'd0, 6'd63, a, b, 32'h0);
    run("R4 shr b ignored", 2'd0, 2'd0, 6'd17, a, ~b, 32'h0);
    run("R5 funnel amt0", 2'd1, 2'd0, 6'd0, a, b, 32'h0);
    run("R5 funnel amt1", 2'd1, 2'd0, 6'd1, a, b, 32'h0);
    run("R5 funnel amt63", 2'd1, 2'd0, 6'd63, a, b, 32'h0);
    for (int lw = 0; lw < 4; lw++) begin
      run("R6 R8 push lo", 2'd2, 2'(lw), 6'd0, a, b, 32'hdead_beef);
      run("R7 R8 push hi", 2'd3, 2'(lw), 6'd0, a, b, 32'hcafe_f00d);
      run("R9 push lo amt/b ignored", 2'd2, 2'(lw), 6'd63, a, ~b, 32'hdead_beef);
      run("R9 push hi amt/b ignored", 2'd3, 2'(lw), 6'd45, a, ~b, 32'hcafe_f00d);
    end

    // R3: idle cycles with changing inputs
    hold = result_o;
    @(negedge clk);
    op_i = 2'd1; amt_i = 6'd5; a_i = rnd_vec(); b_i = rnd_vec(); s_i = $urandom;
    @(negedge clk);
    check("R3 hold result", result_o, hold);
    check("R3 R2 valid low", VW'(valid_o), VW'(0));

    for (int n = 0; n < 300; n++) begin
      run("R4 R5 R6 R7 random", 2'($urandom), 2'($urandom), 6'($urandom),
          rnd_vec(), rnd_vec(), $urandom);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule